// File: doc/BRIEF.md
# Split Instruction/Data Segment Address Translator

This block turns logical addresses from a small pipelined processor into physical ones using two fully separate segments. Instruction fetches, driven by the program counter, go through one segment; loads and stores go through the other. Each segment has a base and a limit. An access is legal when its logical address is below the segment limit. The physical address is the logical address plus the segment base, with wrap-around at the address width.

The data logical address is the register operand plus the immediate. The data physical address is built in one pass. A carry-save layer reduces register operand, immediate and data base to two vectors, and one carry-propagate adder then sums those two vectors. A second adder forms the operand-plus-immediate sum that the limit compare needs.

The four segment registers can be read and written only in kernel mode. A write attempted in user mode changes nothing. It moves a two-state control machine from `CFG_IDLE` to `CFG_REJECT` for one cycle, and in `CFG_REJECT` the privilege-error output is high. Each cycle, a user-mode write goes to `CFG_REJECT` and anything else goes to `CFG_IDLE`, whichever state the machine is in. Translation is combinational: the request, fault and physical address appear in the same cycle as the access.

Top module: `seg_xlate_top`

## Requirements
- R1: After reset all four segment registers read as zero, so every valid fetch or data access faults until the limits are written.
- R2: A valid fetch whose program counter is below the instruction limit gives if_req_valid=1, if_fault=0 and if_paddr = pc + instruction base (mod 2^32) in the same cycle.
- R3: A valid fetch with pc at or above the instruction limit gives if_fault=1 and if_req_valid=0 in the same cycle.
- R4: The limit is exclusive: pc equal to the limit faults, and pc equal to limit-1 is accepted.
- R5: A valid data access whose logical address is below the data limit gives d_paddr = rs + imm + data base (mod 2^32) and d_req_valid=1. The logical address is rs + imm (mod 2^32).
- R6: A valid data access whose logical address (rs + imm mod 2^32) is at or above the data limit gives d_fault=1 and d_req_valid=0 in the same cycle.
- R7: With kernel_mode=1 and cfg_we=1, cfg_wdata is written into the register picked by cfg_sel (0 instruction base, 1 instruction limit, 2 data base, 3 data limit). The new value is in use from the next cycle. With kernel_mode=1, cfg_rdata shows the selected register.
- R8: A write with kernel_mode=0 leaves every register unchanged, and priv_err is high for exactly the following cycle.
- R9: With kernel_mode=0, cfg_rdata reads zero whatever register is selected.
- R10: Fetch and data translations in the same cycle do not interact. A fault on one leaves the other's outputs as its own rules give.
- R11: With if_valid=0 or d_valid=0, the matching request and fault outputs are both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| kernel_mode | input | 1 | Processor is in kernel mode |
| cfg_we | input | 1 | Segment register write strobe |
| cfg_sel | input | 2 | Register select: 0 ibase, 1 ilimit, 2 dbase, 3 dlimit |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Selected register (zero in user mode) |
| priv_err | output | 1 | One-cycle pulse after a user-mode write attempt |
| if_valid | input | 1 | Fetch request |
| if_pc | input | 32 | Fetch logical address |
| if_req_valid | output | 1 | Fetch passed to memory |
| if_paddr | output | 32 | Fetch physical address |
| if_fault | output | 1 | Fetch limit violation |
| d_valid | input | 1 | Data access request |
| d_rs | input | 32 | Register operand |
| d_imm | input | 32 | Immediate (already sign extended) |
| d_req_valid | output | 1 | Data access passed to memory |
| d_paddr | output | 32 | Data physical address |
| d_fault | output | 1 | Data limit violation |

## Verification
The bench probes the exclusive limit edge with pc equal to the limit and one below it. A design using a less-or-equal compare would accept the address that is equal to the limit. It drives data operands whose sum wraps past 2^32, and a data base that wraps the physical address. A wrong carry-save alignment, or a limit compare made on the unwrapped sum, shows up there as a wrong address or a false fault. Writes in user mode are followed by kernel readback, to catch a design that lets the write through or keeps the error pulse high too long. Cycles in which one path faults while the other runs normally catch any coupling between the two segments.

// File: rtl/seg_pkg.sv
package seg_pkg;
    localparam int NUM_SEG_REGS = 4;
    localparam int SEL_W        = $clog2(NUM_SEG_REGS);

    typedef enum logic [SEL_W-1:0] {
        SEL_IBASE  = 2'd0,
        SEL_ILIMIT = 2'd1,
        SEL_DBASE  = 2'd2,
        SEL_DLIMIT = 2'd3
    } seg_sel_e;

    typedef enum logic {
        CFG_IDLE   = 1'b0,
        CFG_REJECT = 1'b1
    } cfg_state_e;
endpackage

// File: rtl/csa3_adder.sv
module csa3_adder #(
    parameter int W = 32
) (
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  logic [W-1:0] op_c,
    output logic [W-1:0] sum
);
    logic [W-1:0] part_sum;
    logic [W-2:0] part_carry;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign part_sum[i] = op_a[i] ^ op_b[i] ^ op_c[i];
        if (i < W - 1) begin : g_carry
            assign part_carry[i] = (op_a[i] & op_b[i]) | (op_a[i] & op_c[i]) | (op_b[i] & op_c[i]);
        end
    end

    // single carry-propagate stage; carry out of the top bit is dropped
    assign sum = part_sum + {part_carry, 1'b0};
endmodule

// File: rtl/seg_cfg_regs.sv
module seg_cfg_regs
    import seg_pkg::*;
#(
    parameter int W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             kernel_mode,
    input  logic             cfg_we,
    input  logic [SEL_W-1:0] cfg_sel,
    input  logic [W-1:0]     cfg_wdata,
    output logic [W-1:0]     cfg_rdata,
    output logic             priv_err,
    output logic [W-1:0]     ibase,
    output logic [W-1:0]     ilimit,
    output logic [W-1:0]     dbase,
    output logic [W-1:0]     dlimit
);
    logic [NUM_SEG_REGS-1:0][W-1:0] regs_q;
    cfg_state_e st_q, st_d;
    logic user_write;

    assign user_write = cfg_we && !kernel_mode;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else if (cfg_we && kernel_mode) begin
            for (int r = 0; r < NUM_SEG_REGS; r++) begin
                if (cfg_sel == SEL_W'(r)) regs_q[r] <= cfg_wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= CFG_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            CFG_IDLE:   st_d = user_write ? CFG_REJECT : CFG_IDLE;
            CFG_REJECT: st_d = user_write ? CFG_REJECT : CFG_IDLE;
            default:    st_d = CFG_IDLE;
        endcase
    end

    always_comb begin
        priv_err  = (st_q == CFG_REJECT);
        cfg_rdata = kernel_mode ? regs_q[cfg_sel] : '0;
    end

    assign ibase  = regs_q[SEL_IBASE];
    assign ilimit = regs_q[SEL_ILIMIT];
    assign dbase  = regs_q[SEL_DBASE];
    assign dlimit = regs_q[SEL_DLIMIT];
endmodule

// File: rtl/seg_limit_unit.sv
module seg_limit_unit #(
    parameter int W       = 32,
    parameter bit USE_CSA = 1'b0
) (
    input  logic         valid,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  logic [W-1:0] base,
    input  logic [W-1:0] limit,
    output logic         req_valid,
    output logic         fault,
    output logic [W-1:0] paddr
);
    logic [W-1:0] logical;
    logic         over;

    assign logical = op_a + op_b;
    assign over    = (logical >= limit);

    if (USE_CSA) begin : g_csa
        csa3_adder #(.W(W)) u_csa (
            .op_a (op_a),
            .op_b (op_b),
            .op_c (base),
            .sum  (paddr)
        );
    end else begin : g_plain
        assign paddr = logical + base;
    end

    assign fault     = valid && over;
    assign req_valid = valid && !over;
endmodule

// File: rtl/seg_xlate_top.sv
module seg_xlate_top
    import seg_pkg::*;
#(
    parameter int W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             kernel_mode,
    input  logic             cfg_we,
    input  logic [SEL_W-1:0] cfg_sel,
    input  logic [W-1:0]     cfg_wdata,
    output logic [W-1:0]     cfg_rdata,
    output logic             priv_err,
    input  logic             if_valid,
    input  logic [W-1:0]     if_pc,
    output logic             if_req_valid,
    output logic [W-1:0]     if_paddr,
    output logic             if_fault,
    input  logic             d_valid,
    input  logic [W-1:0]     d_rs,
    input  logic [W-1:0]     d_imm,
    output logic             d_req_valid,
    output logic [W-1:0]     d_paddr,
    output logic             d_fault
);
    logic [W-1:0] ibase_w, ilimit_w, dbase_w, dlimit_w;

    seg_cfg_regs #(.W(W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .kernel_mode (kernel_mode),
        .cfg_we      (cfg_we),
        .cfg_sel     (cfg_sel),
        .cfg_wdata   (cfg_wdata),
        .cfg_rdata   (cfg_rdata),
        .priv_err    (priv_err),
        .ibase       (ibase_w),
        .ilimit      (ilimit_w),
        .dbase       (dbase_w),
        .dlimit      (dlimit_w)
    );

    seg_limit_unit #(.W(W), .USE_CSA(1'b0)) u_fetch (
        .valid     (if_valid),
        .op_a      (if_pc),
        .op_b      ('0),
        .base      (ibase_w),
        .limit     (ilimit_w),
        .req_valid (if_req_valid),
        .fault     (if_fault),
        .paddr     (if_paddr)
    );

    seg_limit_unit #(.W(W), .USE_CSA(1'b1)) u_data (
        .valid     (d_valid),
        .op_a      (d_rs),
        .op_b      (d_imm),
        .base      (dbase_w),
        .limit     (dlimit_w),
        .req_valid (d_req_valid),
        .fault     (d_fault),
        .paddr     (d_paddr)
    );
endmodule

// File: rtl/seg_xlate_checker.sv
module seg_xlate_checker #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         kernel_mode,
    input logic         cfg_we,
    input logic         priv_err,
    input logic         if_valid,
    input logic [W-1:0] if_pc,
    input logic         if_req_valid,
    input logic         if_fault,
    input logic         d_valid,
    input logic         d_req_valid,
    input logic         d_fault,
    input logic [W-1:0] ilimit_w
);
    a_r3_fault_blocks_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        if_fault |-> !if_req_valid);

    a_r6_fault_blocks_data: assert property (@(posedge clk) disable iff (!rst_n)
        d_fault |-> !d_req_valid);

    a_r11_fetch_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !if_valid |-> (!if_fault && !if_req_valid));

    a_r11_data_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !d_valid |-> (!d_fault && !d_req_valid));

    a_r4_limit_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        (if_valid && if_pc == ilimit_w) |-> if_fault);

    a_r8_reject_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !kernel_mode) |=> priv_err);

    a_r8_pulse_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_we || kernel_mode) |=> !priv_err);
endmodule

bind seg_xlate_top seg_xlate_checker #(.W(W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .kernel_mode  (kernel_mode),
    .cfg_we       (cfg_we),
    .priv_err     (priv_err),
    .if_valid     (if_valid),
    .if_pc        (if_pc),
    .if_req_valid (if_req_valid),
    .if_fault     (if_fault),
    .d_valid      (d_valid),
    .d_req_valid  (d_req_valid),
    .d_fault      (d_fault),
    .ilimit_w     (ilimit_w)
);

// File: tb/seg_xlate_top_bench.sv
`timescale 1ns/1ps
module seg_xlate_top_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        kernel_mode = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = 2'd0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        priv_err;
    logic        if_valid = 1'b0;
    logic [31:0] if_pc = '0;
    logic        if_req_valid;
    logic [31:0] if_paddr;
    logic        if_fault;
    logic        d_valid = 1'b0;
    logic [31:0] d_rs = '0;
    logic [31:0] d_imm = '0;
    logic        d_req_valid;
    logic [31:0] d_paddr;
    logic        d_fault;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // reference state
    logic [31:0] m_reg [4];
    bit          m_perr;

    always #2.5 clk = ~clk;

    seg_xlate_top u_seg_xlate_top (
        .clk(clk), .rst_n(rst_n), .kernel_mode(kernel_mode), .cfg_we(cfg_we),
        .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .priv_err(priv_err), .if_valid(if_valid), .if_pc(if_pc),
        .if_req_valid(if_req_valid), .if_paddr(if_paddr), .if_fault(if_fault),
        .d_valid(d_valid), .d_rs(d_rs), .d_imm(d_imm), .d_req_valid(d_req_valid),
        .d_paddr(d_paddr), .d_fault(d_fault)
    );

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // compare all outputs against the model, then advance one clock
    task automatic cyc(string tag);
        logic [31:0] il, dl, ib, db, dlog;
        bit ef, df;
        @(negedge clk);
        ib = m_reg[0]; il = m_reg[1]; db = m_reg[2]; dl = m_reg[3];
        ef   = if_valid && (if_pc >= il);
        dlog = d_rs + d_imm;
        df   = d_valid && (dlog >= dl);
        chk(tag, "if_fault", 32'(if_fault), 32'(ef));
        chk(tag, "if_req_valid", 32'(if_req_valid), 32'(if_valid && !ef));
        if (if_valid && !ef) chk(tag, "if_paddr", if_paddr, if_pc + ib);
        chk(tag, "d_fault", 32'(d_fault), 32'(df));
        chk(tag, "d_req_valid", 32'(d_req_valid), 32'(d_valid && !df));
        if (d_valid && !df) chk(tag, "d_paddr", d_paddr, dlog + db);
        chk(tag, "cfg_rdata", cfg_rdata, kernel_mode ? m_reg[cfg_sel] : 32'h0);
        chk(tag, "priv_err", 32'(priv_err), 32'(m_perr));
        @(posedge clk);
        if (rst_n) begin
            if (cfg_we && kernel_mode) m_reg[cfg_sel] = cfg_wdata;
            m_perr = cfg_we && !kernel_mode;
        end
        #1;
    endtask

    task automatic kwrite(logic [1:0] sel, logic [31:0] val);
        kernel_mode = 1; cfg_we = 1; cfg_sel = sel; cfg_wdata = val;
        cyc("R7");
        cfg_we = 0;
    endtask

    task automatic fetch(logic [31:0] pc);
        if_valid = 1; if_pc = pc;
    endtask

    task automatic data(logic [31:0] rs, logic [31:0] imm);
        d_valid = 1; d_rs = rs; d_imm = imm;
    endtask

    initial begin
        #1000000;
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 4; i++) m_reg[i] = '0;
        m_perr = 0;
        cyc("R1"); cyc("R1");
        #1 rst_n = 1;
        // R1: zero limits fault everything; kernel readback of zero
        kernel_mode = 1;
        for (int s = 0; s < 4; s++) begin cfg_sel = 2'(s); fetch(32'h0); data(0, 0); cyc("R1"); end
        if_valid = 0; d_valid = 0;
        // R7: configure all four registers and read back
        kwrite(2'd0, 32'h1000_0000);
        kwrite(2'd1, 32'h0000_0100);
        kwrite(2'd2, 32'h2000_0000);
        kwrite(2'd3, 32'h0000_0400);
        for (int s = 0; s < 4; s++) begin cfg_sel = 2'(s); cyc("R7"); end
        // R2: legal fetches
        fetch(32'h0);  cyc("R2");
        fetch(32'h40); cyc("R2");
        // R4: limit edge
        fetch(32'hFF);  cyc("R4");
        fetch(32'h100); cyc("R4");
        // R3: beyond limit
        fetch(32'hFFFF_FFFF); cyc("R3");
        fetch(32'h2000);      cyc("R3");
        if_valid = 0;
        // R5: data addresses, negative immediate, operand wrap
        data(32'h10, 32'h20);           cyc("R5");
        data(32'h100, 32'hFFFF_FFFC);   cyc("R5");
        data(32'hFFFF_FFFF, 32'h2);     cyc("R5");
        // R6: data limit edge and beyond
        data(32'h3FF, 32'h1); cyc("R6");
        data(32'h3FF, 32'h0); cyc("R6");
        data(32'h8000_0000, 32'h0); cyc("R6");
        d_valid = 0;
        // R5: physical address wrap through data base
        kwrite(2'd2, 32'hFFFF_FFF0);
        data(32'h18, 32'h8); cyc("R5");
        d_valid = 0;
        // R8: user-mode writes ignored, one-cycle error pulse
        kernel_mode = 0; cfg_we = 1; cfg_sel = 2'd1; cfg_wdata = 32'hDEAD_BEEF;
        cyc("R8");
        cfg_we = 0; cyc("R8"); cyc("R8");
        kernel_mode = 1; cfg_sel = 2'd1; cyc("R8");
        fetch(32'h100); cyc("R8");
        if_valid = 0;
        // R9: user-mode read returns zero
        kernel_mode = 0;
        for (int s = 0; s < 4; s++) begin cfg_sel = 2'(s); cyc("R9"); end
        // R10: simultaneous paths, one faulting
        fetch(32'h500); data(32'h10, 32'h0); cyc("R10");
        fetch(32'h10);  data(32'h500, 32'h0); cyc("R10");
        fetch(32'h80);  data(32'h80, 32'h4);  cyc("R10");
        // R11: idle inputs give quiet outputs
        if_valid = 0; d_valid = 0; if_pc = 32'h5000; d_rs = 32'h9000; cyc("R11");
        // mixed traffic around the limits
        for (int n = 0; n < 300; n++) begin
            kernel_mode = $urandom_range(0, 1);
            cfg_we      = ($urandom_range(0, 9) == 0);
            cfg_sel     = 2'($urandom_range(0, 3));
            cfg_wdata   = $urandom_range(0, 2048);
            if_valid    = $urandom_range(0, 1);
            if_pc       = $urandom_range(0, 2048);
            d_valid     = $urandom_range(0, 1);
            d_rs        = $urandom_range(0, 1024);
            d_imm       = $urandom_range(0, 1024);
            cyc("R10");
        end
        cfg_we = 0; if_valid = 0; d_valid = 0;
        cyc("R11");
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule